// File: doc/BRIEF.md
# Serial Receive/Transmit Double-Buffered Data Register

This block is the data path between the bit-level engine of a two-wire serial peripheral and the CPU register port. It holds a shift stage that takes received bits in one at a time, or hands out transmit bits one at a time. Beside it sits a receive buffer that the CPU reads. In receive mode a finished frame moves into the buffer at once if the buffer is free. If the buffer already holds an unread byte, the new frame stays in the shift stage until the CPU reads the buffer. A full flag and a held-frame flag show where the data currently sits.

Frames may be 1 to 8 bits long. A bit-order input picks the shift direction: MSB-first (0) or LSB-first (1). That choice also decides where a short frame lands in the byte. Received short frames end up at the LSB end (order 0) or the MSB end (order 1). Transmit data for short frames must be justified toward the MSB (order 0) or the LSB (order 1).

The receive buffer is a three-state machine. `BUF_EMPTY` goes to `BUF_FULL` when a receive frame ends. `BUF_FULL` goes to `BUF_EMPTY` on a CPU read. `BUF_FULL` goes to `BUF_HELD` when a second receive frame ends with no read in the same cycle. If a read and a frame end come together, the state stays `BUF_FULL` and the new frame goes straight into the buffer. `BUF_HELD` goes to `BUF_FULL` on a CPU read, which copies the held frame into the buffer.

Top module: `sdr_dbuf`

## Requirements
- R1: Reset clears `buf_full`, `rx_held` and `frame_done`. Reset does not define the receive buffer contents.
- R2: Each accepted `bit_tick` shifts the shift stage once. With `lsb_first`=0 it shifts left and `bit_in` enters bit 0. With `lsb_first`=1 it shifts right and `bit_in` enters bit 7. A received n-bit frame therefore sits at the LSB end or the MSB end.
- R3: A frame ends on the tick that brings the bit count to the length. `frame_len` of 1 to 7 means that many bits and 0 means 8. If `rx_mode`=1 and the buffer is empty, the new shift-stage value goes into the buffer on that edge and `buf_full` rises.
- R4: If a receive frame ends while the buffer is full and no read comes in that cycle, the frame stays in the shift stage and `rx_held` rises. While `rx_held`=1, `bit_tick` is ignored.
- R5: A CPU read while `rx_held`=1 copies the held frame into the buffer, clears `rx_held` and leaves `buf_full` at 1.
- R6: A CPU read while the buffer is full and nothing is held clears `buf_full`.
- R7: With `rx_mode`=0, a finished frame never changes the buffer, `buf_full` or `rx_held`.
- R8: A CPU write loads `cpu_wdata` into the shift stage and restarts the bit count. `tx_bit` is bit 7 of the shift stage when `lsb_first`=0 and bit 0 when it is 1. A write has priority over a tick in the same cycle.
- R9: While `enable`=0, `cpu_rd` and `cpu_wr` have no effect and `cpu_rdata` reads 0. While `enable`=1, `cpu_rdata` shows the buffer.
- R10: `frame_done` is a one-cycle pulse in the cycle after every frame end, in either mode.
- R11: A CPU write while `rx_held`=1 is ignored, so the held frame is kept.
- R12: If a CPU read and a receive frame end come in the same cycle while the buffer is full and nothing is held, the new frame goes straight into the buffer and `buf_full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; gates CPU accesses |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| lsb_first | input | 1 | Bit order: 0 MSB-first, 1 LSB-first |
| frame_len | input | 3 | Data bits per frame, 0 means 8 |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Receive buffer read data |
| bit_tick | input | 1 | Shift-engine bit strobe |
| bit_in | input | 1 | Received serial bit |
| tx_bit | output | 1 | Serial bit to transmit |
| frame_done | output | 1 | Pulse after a frame ends |
| buf_full | output | 1 | Receive buffer holds unread data |
| rx_held | output | 1 | A finished frame is waiting in the shift stage |

## Verification
The properties assume that every control input is a known 0 or 1 at each clock edge. They also assume that `frame_len` and `lsb_first` hold their values across the sampling edge. The bench drives all inputs half a cycle away from the active edge, from a fixed-seed generator, so they are always defined and stable when sampled. The random mix of ticks, reads, writes, mode flips and length changes often makes frames end while the buffer is full and reads fall on frame-end cycles. Directed sequences add the cases with the buffer disabled, writes while a frame is held, and transmit-only runs.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,
        BUF_FULL  = 2'd1,
        BUF_HELD  = 2'd2
    } buf_state_e;
endpackage

// File: rtl/sdr_shift_stage.sv
module sdr_shift_stage #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    input  logic              bit_in,
    input  logic              hold,
    output logic [DATA_W-1:0] sr_q,
    output logic [DATA_W-1:0] sr_shifted,
    output logic              frm_end,
    output logic              tx_bit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    logic             adv;

    // a length code of 0 wraps to DATA_W-1, i.e. a full-width frame
    assign last_idx = frame_len - CNT_W'(1);
    assign adv      = tick && !hold && !load;
    assign frm_end  = adv && (cnt_q == last_idx);

    always_comb begin
        if (lsb_first) sr_shifted = {bit_in, sr_q[DATA_W-1:1]};
        else           sr_shifted = {sr_q[DATA_W-2:0], bit_in};
    end

    assign tx_bit = lsb_first ? sr_q[0] : sr_q[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sr_q  <= load_data;
            cnt_q <= '0;
        end else if (adv) begin
            sr_q  <= sr_shifted;
            cnt_q <= frm_end ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sdr_rx_buffer.sv
module sdr_rx_buffer
    import sdr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              frm_end,
    input  logic              rd_ok,
    input  logic [DATA_W-1:0] new_frame,
    input  logic [DATA_W-1:0] held_frame,
    output logic [DATA_W-1:0] rbuf_q,
    output logic              full,
    output logic              held
);
    buf_state_e       state_q, state_d;
    logic             rx_end;
    logic             cap_new, cap_held;

    assign rx_end = frm_end && rx_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cap_new  = 1'b0;
        cap_held = 1'b0;
        unique case (state_q)
            BUF_EMPTY: begin
                if (rx_end) begin
                    state_d = BUF_FULL;
                    cap_new = 1'b1;
                end
            end
            BUF_FULL: begin
                if (rx_end && rd_ok) begin
                    cap_new = 1'b1;
                end else if (rx_end) begin
                    state_d = BUF_HELD;
                end else if (rd_ok) begin
                    state_d = BUF_EMPTY;
                end
            end
            BUF_HELD: begin
                if (rd_ok) begin
                    state_d  = BUF_FULL;
                    cap_held = 1'b1;
                end
            end
            default: state_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (cap_new)       rbuf_q <= new_frame;
        else if (cap_held) rbuf_q <= held_frame;
    end

    always_comb begin
        full = (state_q == BUF_FULL) || (state_q == BUF_HELD);
        held = (state_q == BUF_HELD);
    end
endmodule

// File: rtl/sdr_dbuf.sv
module sdr_dbuf #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_mode,
    input  logic              lsb_first,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              bit_tick,
    input  logic              bit_in,
    output logic              tx_bit,
    output logic              frame_done,
    output logic              buf_full,
    output logic              rx_held
);
    logic              wr_ok, rd_ok, frm_end;
    logic [DATA_W-1:0] sr_q, sr_shifted, rbuf_q;

    assign wr_ok = enable && cpu_wr && !rx_held;
    assign rd_ok = enable && cpu_rd;

    sdr_shift_stage #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .lsb_first  (lsb_first),
        .frame_len  (frame_len),
        .load       (wr_ok),
        .load_data  (cpu_wdata),
        .tick       (bit_tick),
        .bit_in     (bit_in),
        .hold       (rx_held),
        .sr_q       (sr_q),
        .sr_shifted (sr_shifted),
        .frm_end    (frm_end),
        .tx_bit     (tx_bit)
    );

    sdr_rx_buffer #(.DATA_W(DATA_W)) u_rxbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_mode    (rx_mode),
        .frm_end    (frm_end),
        .rd_ok      (rd_ok),
        .new_frame  (sr_shifted),
        .held_frame (sr_q),
        .rbuf_q     (rbuf_q),
        .full       (buf_full),
        .held       (rx_held)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_done <= 1'b0;
        else        frame_done <= frm_end;
    end

    assign cpu_rdata = enable ? rbuf_q : '0;
endmodule

// File: rtl/sdr_dbuf_chk.sv
module sdr_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic rx_mode,
    input logic cpu_rd,
    input logic frm_end,
    input logic frame_done,
    input logic buf_full,
    input logic rx_held
);
    logic rd_ok;
    assign rd_ok = enable && cpu_rd;

    p_held_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_held |-> buf_full);

    p_held_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_held && !rd_ok |=> rx_held);

    p_promote_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_held && rd_ok |=> buf_full && !rx_held);

    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && !rx_held && rd_ok && !(frm_end && rx_mode) |=> !buf_full);

    p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_full && frm_end && rx_mode |=> buf_full && !rx_held);

    p_tx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mode && !rd_ok |=> $stable(buf_full) && $stable(rx_held));

    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && buf_full |=> buf_full);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |=> frame_done);

    p_pass_through_r12: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && !rx_held && rd_ok && frm_end && rx_mode |=> buf_full && !rx_held);
endmodule

bind sdr_dbuf sdr_dbuf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .rx_mode    (rx_mode),
    .cpu_rd     (cpu_rd),
    .frm_end    (frm_end),
    .frame_done (frame_done),
    .buf_full   (buf_full),
    .rx_held    (rx_held)
);

// File: tb/test_sdr_dbuf.sv
module test_sdr_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, rx_mode = 1'b0, lsb_first = 1'b0;
    logic [2:0] frame_len = 3'd0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, bit_tick = 1'b0, bit_in = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       tx_bit, frame_done, buf_full, rx_held;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    // bench-side model of the requirements
    logic [7:0] m_sr = 8'h00, m_rbuf = 8'h00;
    logic [2:0] m_cnt = 3'd0;
    logic       m_full = 0, m_held = 0, m_done = 0, m_known = 0;

    always #5 clk = ~clk;

    sdr_dbuf i_sdr_dbuf (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx_mode(rx_mode),
        .lsb_first(lsb_first), .frame_len(frame_len), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .bit_tick(bit_tick), .bit_in(bit_in), .tx_bit(tx_bit),
        .frame_done(frame_done), .buf_full(buf_full), .rx_held(rx_held)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] shift_of(input logic [7:0] s, input logic lsb, input logic b);
        return lsb ? {b, s[7:1]} : {s[6:0], b};
    endfunction

    // advance the model by one clock edge with the inputs currently driven
    task automatic model_step();
        logic wr_ok, rd_ok, adv, fe, rxe;
        logic [7:0] sh;
        wr_ok = enable && cpu_wr && !m_held;
        rd_ok = enable && cpu_rd;
        adv   = bit_tick && !m_held && !wr_ok;
        sh    = shift_of(m_sr, lsb_first, bit_in);
        fe    = adv && (m_cnt == frame_len - 3'd1);
        rxe   = fe && rx_mode;
        m_done = fe;
        if (!m_full) begin
            if (rxe) begin m_full = 1; m_rbuf = sh; m_known = 1; end
        end else if (!m_held) begin
            if (rxe && rd_ok) m_rbuf = sh;
            else if (rxe) m_held = 1;
            else if (rd_ok) m_full = 0;
        end else if (rd_ok) begin
            m_held = 0; m_rbuf = m_sr;
        end
        if (wr_ok) begin m_sr = cpu_wdata; m_cnt = 0; end
        else if (adv) begin m_sr = sh; m_cnt = fe ? 3'd0 : m_cnt + 3'd1; end
    endtask

    // compare all outputs against the model, inputs still applied
    task automatic check_all();
        chk("R3 R5 R6 buf_full", {7'd0, buf_full}, {7'd0, m_full});
        chk("R4 rx_held", {7'd0, rx_held}, {7'd0, m_held});
        chk("R8 tx_bit", {7'd0, tx_bit}, {7'd0, lsb_first ? m_sr[0] : m_sr[7]});
        chk("R10 frame_done", {7'd0, frame_done}, {7'd0, m_done});
        if (!enable)      chk("R9 rdata disabled", cpu_rdata, 8'h00);
        else if (m_known) chk("R2 rdata", cpu_rdata, m_rbuf);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
        cpu_wr = 0; cpu_rd = 0; bit_tick = 0;
    endtask

    task automatic send_bits(input int n, input logic [7:0] pat);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; bit_in = pat[i];
            cyc();
        end
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (2) @(negedge clk);
        chk("R1 buf_full", {7'd0, buf_full}, 8'd0);
        chk("R1 rx_held", {7'd0, rx_held}, 8'd0);
        chk("R1 frame_done", {7'd0, frame_done}, 8'd0);
        rst_n = 1;
        @(negedge clk);

        // R3/R2: 8-bit MSB-first receive into empty buffer
        enable = 1; rx_mode = 1; lsb_first = 0; frame_len = 0;
        send_bits(8, 8'b1011_0010);
        chk("R3 full after frame", {7'd0, buf_full}, 8'd1);
        // R4: second 3-bit frame while full is held
        frame_len = 3;
        send_bits(3, 8'b0000_0101);
        chk("R4 held", {7'd0, rx_held}, 8'd1);
        send_bits(2, 8'b11);
        chk("R4 ticks ignored while held", {7'd0, rx_held}, 8'd1);
        // R11: write while held ignored
        cpu_wr = 1; cpu_wdata = 8'hA5; cyc();
        // R5: read promotes held frame
        cpu_rd = 1; cyc();
        chk("R5 full stays", {7'd0, buf_full}, 8'd1);
        chk("R11 held frame kept", cpu_rdata, m_rbuf);
        // R9: disabled read ignored
        enable = 0; cpu_rd = 1; cyc();
        chk("R9 full after disabled read", {7'd0, buf_full}, 8'd1);
        enable = 1;
        // R12: read coinciding with frame end, LSB-first 5-bit
        lsb_first = 1; frame_len = 5;
        send_bits(4, 8'b0110);
        cpu_rd = 1; bit_tick = 1; bit_in = 1; cyc();
        chk("R12 pass-through full", {7'd0, buf_full}, 8'd1);
        // R6: plain read empties
        cpu_rd = 1; cyc();
        chk("R6 emptied", {7'd0, buf_full}, 8'd0);
        // R7/R8: transmit a 6-bit frame, no fill
        rx_mode = 0; lsb_first = 0; frame_len = 6;
        cpu_wr = 1; cpu_wdata = 8'b1101_0100; cyc();
        send_bits(6, 8'h00);
        chk("R7 tx no fill", {7'd0, buf_full}, 8'd0);

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            enable    = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 40) == 0) rx_mode   = ~rx_mode;
            if ($urandom_range(0, 60) == 0) lsb_first = ~lsb_first;
            if ($urandom_range(0, 50) == 0) frame_len = 3'($urandom_range(0, 7));
            bit_tick  = ($urandom_range(0, 3) != 0);
            bit_in    = 1'($urandom);
            cpu_rd    = ($urandom_range(0, 11) == 0);
            cpu_wr    = ($urandom_range(0, 29) == 0);
            cpu_wdata = 8'($urandom);
            cyc();
        end
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule